// File: doc/BRIEF.md
# Two-Channel DMA Bus Arbiter

This block decides which of two DMA channels owns the bus and runs each granted transfer as two bus cycles: a fetch cycle, then a deposit cycle. Each channel is configured with a priority level (high or low), a synchronization mode (source-synchronized or destination-synchronized) and a request source. The request source is either the channel's own external request line or a timer request that both channels share.

Arbitration happens only between transfers: while the bus is idle, and during the deposit cycle of the running transfer. A destination-synchronized channel must leave the bus free for two idle states after each of its deposits. This allows a pending lower-priority channel to complete one whole transfer in that gap. When both channels keep requesting, their transfers therefore interleave. A source-synchronized high-priority channel has no such gap, so it keeps the bus with back-to-back transfers. When the two priorities are equal, the channels take turns.

Top module: `dma_pair_arbiter`

## Requirements
- R1: When both channels are eligible at the same decision point and their priority levels differ, the channel with `prio_hi` set performs the next transfer.
- R2: Every transfer is exactly one cycle with `grant`=1, `deposit`=0 (fetch), followed by one cycle with `grant`=1, `deposit`=1 (deposit). `chan_id` holds the same value in both cycles.
- R3: After a deposit by a channel with `dst_sync` set, that channel does not fetch in the next two cycles. If no other channel requests, `idle` is 1 for exactly those two cycles before its next fetch.
- R4: During the two idle states of a higher-priority destination-synchronized channel, a pending lower-priority channel performs one full transfer, and then the higher channel regains the bus.
- R5: While both requests stay asserted and the high-priority channel is destination-synchronized, successive transfers alternate between channel 0 and channel 1.
- R6: A high-priority channel with `dst_sync`=0 whose request stays asserted performs back-to-back transfers, and the low-priority channel gets no transfer.
- R7: A request from the higher-priority channel takes over from a running lower-priority channel at the next transfer boundary. The deposit cycle of the running transfer always completes first.
- R8: With equal priorities and both channels requesting, the channels alternate transfer by transfer, and channel 0 goes first after reset.
- R9: Channel c uses `timer_req` as its request when `src_sel[c]`=1, and `ext_req[c]` when `src_sel[c]`=0. The input that is not selected has no effect on grants.
- R10: After reset, and whenever no channel is eligible at a decision point, the arbiter is idle: `grant`=0 and `idle`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_req | input | 2 | External request line for each channel |
| timer_req | input | 1 | Shared timer request |
| src_sel | input | 2 | Request source per channel: 1 = timer, 0 = external line |
| prio_hi | input | 2 | Priority level per channel: 1 = high |
| dst_sync | input | 2 | Synchronization mode per channel: 1 = destination, 0 = source |
| grant | output | 1 | Bus is owned by a channel |
| chan_id | output | 1 | Channel that owns the bus |
| deposit | output | 1 | 1 in the deposit cycle, 0 in the fetch cycle |
| idle | output | 1 | Bus is free |

## Verification
The assertions check the following on every cycle:
- The fetch-then-deposit shape of each transfer, with a fixed channel ID.
- The exclusion of a destination-synchronized channel while its idle-state counter blocks it.
- The winner of a priority contest and of a round-robin contest.
- The return to idle when nothing is eligible.

Some behaviours only show up as sequences over many cycles, and only the bench scenarios can demonstrate them: the interleaving of the two channels, the exact count of idle cycles, the takeover at a boundary, the round-robin starting order after reset, and the effect of each request source selection. For these, the bench runs its own behavioural reference model on every clock and inspects a log of fetch events.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_FETCH   = 2'd1,
    PH_DEPOSIT = 2'd2
  } phase_e;

  // Winner among eligible channels: a differing priority decides,
  // otherwise the round-robin pointer decides.
  function automatic logic pick_winner(input logic [1:0] elig,
                                       input logic [1:0] prio_hi,
                                       input logic       rr);
    logic w;
    case (elig)
      2'b01:   w = 1'b0;
      2'b10:   w = 1'b1;
      2'b11:   w = (prio_hi[0] != prio_hi[1]) ? prio_hi[1] : rr;
      default: w = rr;
    endcase
    return w;
  endfunction

  // Next value of an idle-state counter.
  function automatic int unsigned hold_next(input int unsigned cur,
                                            input logic        arm,
                                            input int unsigned n_idle);
    int unsigned nx;
    if (arm)          nx = n_idle;
    else if (cur > 0) nx = cur - 1;
    else              nx = 0;
    return nx;
  endfunction

endpackage

// File: rtl/dma_req_select.sv
module dma_req_select #(
  parameter int NCH = 2
) (
  input  logic [NCH-1:0] ext_req,
  input  logic           timer_req,
  input  logic [NCH-1:0] src_sel,
  output logic [NCH-1:0] req_eff
);
  for (genvar c = 0; c < NCH; c++) begin : g_mux
    assign req_eff[c] = src_sel[c] ? timer_req : ext_req[c];
  end
endmodule

// File: rtl/dma_idle_hold.sv
module dma_idle_hold #(
  parameter int IDLE_STATES = 2,
  parameter int CNT_W       = $clog2(IDLE_STATES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  output logic blocked
);
  import dma_arb_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  int unsigned      cnt_nx;

  always_comb cnt_nx = hold_next(int'(cnt_q), arm, IDLE_STATES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= CNT_W'(cnt_nx);
  end

  // Blocked in the deposit cycle itself and while more than one idle state remains.
  assign blocked = arm || (int'(cnt_q) > 1);

  // R3: the counter never exceeds the configured number of idle states
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= IDLE_STATES);
endmodule

// File: rtl/dma_chan_pick.sv
module dma_chan_pick (
  input  logic [1:0] elig,
  input  logic [1:0] prio_hi,
  input  logic       rr,
  output logic       win,
  output logic       any
);
  import dma_arb_pkg::*;

  assign win = pick_winner(elig, prio_hi, rr);
  assign any = |elig;

  // R1: a winner is always one of the eligible channels
  always_comb begin
    if (any) a_r1_win_eligible: assert (elig[win]);
  end
endmodule

// File: rtl/dma_pair_arbiter.sv
module dma_pair_arbiter #(
  parameter int IDLE_STATES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ext_req,
  input  logic       timer_req,
  input  logic [1:0] src_sel,
  input  logic [1:0] prio_hi,
  input  logic [1:0] dst_sync,
  output logic       grant,
  output logic       chan_id,
  output logic       deposit,
  output logic       idle
);
  import dma_arb_pkg::*;

  localparam int NCH   = 2;
  localparam int CNT_W = $clog2(IDLE_STATES + 1);

  phase_e         phase_q, phase_d;
  logic           chan_q, chan_d;
  logic           rr_q, rr_d;
  logic [NCH-1:0] req_eff, arm, blocked, elig;
  logic           boundary, win, any_elig;

  dma_req_select #(.NCH(NCH)) u_sel (
    .ext_req  (ext_req),
    .timer_req(timer_req),
    .src_sel  (src_sel),
    .req_eff  (req_eff)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_hold
    assign arm[c] = (phase_q == PH_DEPOSIT) && (chan_q == 1'(c)) && dst_sync[c];

    dma_idle_hold #(.IDLE_STATES(IDLE_STATES), .CNT_W(CNT_W)) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm    (arm[c]),
      .blocked(blocked[c])
    );

    // R3: a blocked channel is never the one fetching in the following cycle
    a_r3_blocked_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      blocked[c] |=> !(grant && !deposit && chan_id == 1'(c)));
  end

  assign elig     = req_eff & ~blocked;
  assign boundary = (phase_q != PH_FETCH);

  dma_chan_pick u_pick (
    .elig   (elig),
    .prio_hi(prio_hi),
    .rr     (rr_q),
    .win    (win),
    .any    (any_elig)
  );

  always_comb begin
    phase_d = phase_q;
    chan_d  = chan_q;
    rr_d    = rr_q;
    if (phase_q == PH_FETCH) begin
      phase_d = PH_DEPOSIT;
    end else if (any_elig) begin
      phase_d = PH_FETCH;
      chan_d  = win;
      rr_d    = ~win;
    end else begin
      phase_d = PH_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      chan_q  <= 1'b0;
      rr_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      chan_q  <= chan_d;
      rr_q    <= rr_d;
    end
  end

  assign grant   = (phase_q != PH_IDLE);
  assign chan_id = chan_q;
  assign deposit = (phase_q == PH_DEPOSIT);
  assign idle    = (phase_q == PH_IDLE);

  // R2: a fetch cycle is followed by a deposit cycle of the same channel
  a_r2_fetch_then_deposit: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !deposit) |=> (grant && deposit && $stable(chan_id)));

  // R1: a priority contest goes to the high-priority channel
  a_r1_high_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && (&elig) && (prio_hi[0] != prio_hi[1])) |=> (chan_id == $past(prio_hi[1])));

  // R8: an equal-priority contest goes to the channel the turn pointer names
  a_r8_turn_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && (&elig) && (prio_hi[0] == prio_hi[1])) |=> (chan_id == $past(rr_q)));

  // R10: nothing eligible at a decision point leaves the bus idle
  a_r10_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !any_elig) |=> (idle && !grant));

  // R7: a running transfer is never cut between fetch and deposit
  a_r7_no_split: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !deposit) |=> grant);
endmodule

// File: tb/dma_pair_arbiter_tb.sv
`timescale 1ns/1ps
module dma_pair_arbiter_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] ext_req = 2'b00;
  logic       timer_req = 1'b0;
  logic [1:0] src_sel = 2'b00;
  logic [1:0] prio_hi = 2'b00;
  logic [1:0] dst_sync = 2'b00;
  logic       grant, chan_id, deposit, idle;

  always #5 clk = ~clk;

  dma_pair_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .ext_req(ext_req), .timer_req(timer_req),
    .src_sel(src_sel), .prio_hi(prio_hi), .dst_sync(dst_sync),
    .grant(grant), .chan_id(chan_id), .deposit(deposit), .idle(idle)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 0;
  string cur_req = "R10";
  int    fetch_log[$];

  // Behavioural reference: phase 0 idle, 1 fetch, 2 deposit
  int m_ph, m_ch, m_rr, pick;
  int m_hold[2];
  int nh[2];
  bit r_in[2];
  bit ok[2];
  bit self_arm;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_ch = 0; m_rr = 0; m_hold[0] = 0; m_hold[1] = 0;
    end else begin
      for (int c = 0; c < 2; c++) begin
        r_in[c]  = src_sel[c] ? timer_req : ext_req[c];
        self_arm = (m_ph == 2) && (m_ch == c) && dst_sync[c];
        ok[c]    = r_in[c] && !self_arm && (m_hold[c] < 2);
        nh[c]    = self_arm ? 2 : ((m_hold[c] > 0) ? m_hold[c] - 1 : 0);
      end
      if (m_ph == 1) begin
        m_ph = 2;
      end else begin
        if (ok[0] && ok[1]) pick = (prio_hi[0] != prio_hi[1]) ? (prio_hi[1] ? 1 : 0) : m_rr;
        else if (ok[0])     pick = 0;
        else if (ok[1])     pick = 1;
        else                pick = -1;
        if (pick >= 0) begin m_ph = 1; m_ch = pick; m_rr = 1 - pick; end
        else m_ph = 0;
      end
      m_hold[0] = nh[0]; m_hold[1] = nh[1];
    end
  end

  // Every-cycle comparison with the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_tests++;
      if (grant !== (m_ph != 0) || idle !== (m_ph == 0) || deposit !== (m_ph == 2) ||
          (m_ph != 0 && chan_id !== m_ch[0])) begin
        n_fail++;
        $display("FAIL %s model: got grant=%b ch=%b dep=%b idle=%b, expected grant=%0d ch=%0d dep=%0d idle=%0d",
                 cur_req, grant, chan_id, deposit, idle, m_ph != 0, m_ch, m_ph == 2, m_ph == 0);
      end
      if (grant && !deposit) fetch_log.push_back(int'(chan_id));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic chk(input bit good, input string tag, input string what, input int act, input int exp);
    n_tests++;
    if (!good) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic quiet();
    ext_req = 2'b00; timer_req = 1'b0; src_sel = 2'b00;
    tick(5);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
  endtask

  initial begin
    int cnt;
    int alt;
    do_reset();
    // R10: reset state
    cur_req = "R10";
    tick(1);
    chk(grant == 0 && idle == 1, "R10", "idle after reset", int'(grant), 0);

    // R1 and R6: c1 high, source-synchronized, both requesting
    cur_req = "R6";
    prio_hi = 2'b10; dst_sync = 2'b00; ext_req = 2'b11;
    fetch_log.delete();
    tick(12);
    chk(fetch_log.size() == 6, "R6", "back-to-back fetch count", fetch_log.size(), 6);
    chk(fetch_log[0] == 1, "R1", "first transfer channel", fetch_log[0], 1);
    cnt = 0;
    foreach (fetch_log[i]) if (fetch_log[i] != 1) cnt++;
    chk(cnt == 0, "R6", "low-priority fetches", cnt, 0);

    // R3: c1 destination-synchronized alone: F D I I
    quiet();
    chk(idle == 1, "R10", "idle with no request", int'(idle), 1);
    cur_req = "R3";
    dst_sync = 2'b10; ext_req = 2'b10;
    cnt = 0; alt = 0;
    for (int i = 0; i < 12; i++) begin
      tick(1);
      cnt += int'(idle);
      if (grant && !deposit) alt++;
    end
    chk(cnt == 6, "R3", "idle cycles in 12", cnt, 6);
    chk(alt == 3, "R3", "fetches in 12", alt, 3);

    // R4 and R5: c0 joins during the idle states
    cur_req = "R5";
    ext_req = 2'b11;
    fetch_log.delete();
    tick(17);
    chk(fetch_log.size() >= 4, "R5", "fetch count", fetch_log.size(), 4);
    cnt = 0;
    for (int i = 0; i + 1 < fetch_log.size(); i++) if (fetch_log[i] == fetch_log[i+1]) cnt++;
    chk(cnt == 0, "R5", "repeated channel in sequence", cnt, 0);
    alt = 0;
    for (int i = 0; i + 1 < fetch_log.size(); i++) if (fetch_log[i] == 0 && fetch_log[i+1] == 1) alt++;
    chk(alt >= 1, "R4", "low transfer then high regains", alt, 1);

    // R7 and R2: takeover at the boundary
    quiet();
    cur_req = "R7";
    dst_sync = 2'b00; prio_hi = 2'b10; ext_req = 2'b01;
    tick(1);
    chk(grant && !deposit && chan_id == 0, "R2", "fetch c0", int'(deposit), 0);
    tick(1);
    chk(grant && deposit && chan_id == 0, "R2", "deposit c0 same channel", int'(chan_id), 0);
    tick(1);
    ext_req = 2'b11;
    tick(1);
    chk(grant && deposit && chan_id == 0, "R7", "running transfer completes", int'(chan_id), 0);
    tick(1);
    chk(grant && !deposit && chan_id == 1, "R7", "high channel takes over", int'(chan_id), 1);

    // R8: equal priority round robin after reset
    ext_req = 2'b00;
    do_reset();
    cur_req = "R8";
    prio_hi = 2'b00; dst_sync = 2'b00; ext_req = 2'b11;
    fetch_log.delete();
    tick(8);
    chk(fetch_log.size() == 4, "R8", "fetch count", fetch_log.size(), 4);
    chk(fetch_log[0] == 0, "R8", "first channel after reset", fetch_log[0], 0);
    cnt = 0;
    for (int i = 0; i + 1 < fetch_log.size(); i++) if (fetch_log[i] == fetch_log[i+1]) cnt++;
    chk(cnt == 0, "R8", "turns alternate", cnt, 0);

    // R9: source selection
    quiet();
    cur_req = "R9";
    src_sel = 2'b11; ext_req = 2'b11; timer_req = 1'b0;
    cnt = 0;
    for (int i = 0; i < 6; i++) begin tick(1); cnt += int'(grant); end
    chk(cnt == 0, "R9", "grants from unselected external lines", cnt, 0);
    src_sel = 2'b01; ext_req = 2'b00; timer_req = 1'b1; prio_hi = 2'b00;
    tick(1);
    chk(grant && chan_id == 0, "R9", "c0 served from timer", int'(chan_id), 0);
    src_sel = 2'b00; ext_req = 2'b10;
    tick(6);

    quiet();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule